// File: doc/BRIEF.md
# GPIO Output Register Bank with Direction-Gated Set/Clear Strobes

This block is a 32-bit general-purpose I/O peripheral controlled through a word-addressed register port. It holds three 32-bit registers: a level register that drives the pin outputs, a direction register that drives the per-pin output enables, and a spare scratch register that software may use freely. Software never writes the level register directly. It changes output levels by writing a bit mask to a set strobe address or to a clear strobe address.

A strobe takes effect only when its mask has at least one bit in common with the direction register. An accepted strobe applies the whole mask, and that includes bits currently configured as inputs. A strobe whose mask has no bit in common with the direction register is dropped as a whole, and a one-cycle error pulse reports the drop. Three further addresses are reserved for edge configuration and edge status. Writes to them are accepted and have no effect. Read data is registered, and all accesses are full 32-bit words.

Top module: `gpio_strobe_bank`

## Requirements
- R1: After reset the level, direction and scratch registers are zero, `pin_out` and `pin_oe` are zero, `rd_data` is zero and `strobe_err` is low.
- R2: A read issued with `rd_en` high in cycle N presents its data on `rd_data` in cycle N+1. Offset 0x00 returns the level register, 0x04 returns the direction register and 0x20 returns the scratch register. Any other offset returns zero. When `rd_en` is low, `rd_data` holds its previous value.
- R3: A write to offset 0x04 loads the direction register, and a write to offset 0x20 loads the scratch register. Both take effect at the write's clock edge.
- R4: A write to offset 0x08 whose data overlaps the direction register ORs the full data into the level register.
- R5: A write to offset 0x0C whose data overlaps the direction register clears every level bit that is set in the data.
- R6: A set or clear strobe whose data has no bit in common with the direction register leaves the level register unchanged. In that case `strobe_err` is high for exactly the cycle after the write.
- R7: Writes to offsets 0x10, 0x14 and 0x18, and to any unmapped offset, change no register and raise no error.
- R8: `pin_out` always equals the level register and `pin_oe` always equals the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Byte offset of the word access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pin_out | output | 32 | Output pin levels |
| pin_oe | output | 32 | Per-pin output enable |
| strobe_err | output | 1 | One-cycle pulse when a set or clear strobe is dropped |

## Verification
The strobes are driven with several kinds of mask. A mask that lies wholly inside the direction mask checks the ordinary set and clear paths. A mask that overlaps the direction mask only partly shows whether input-direction bits are written as well. A mask that is disjoint from the direction mask, and a direction mask of zero, must both be rejected, which tells whole-strobe rejection apart from per-bit masking. Writes to the reserved edge offsets and to unmapped offsets, followed by reads of every offset, show that no register was touched.

// File: rtl/gpio_strobe_pkg.sv
package gpio_strobe_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;

  typedef enum logic [AW-1:0] {
    OFS_LEVEL = 6'h00,
    OFS_DIR   = 6'h04,
    OFS_SET   = 6'h08,
    OFS_CLR   = 6'h0C,
    OFS_RISE  = 6'h10,
    OFS_FALL  = 6'h14,
    OFS_EDGE  = 6'h18,
    OFS_AUX   = 6'h20
  } ofs_e;

  typedef struct packed {
    logic wr_dir;
    logic wr_aux;
    logic set_stb;
    logic clr_stb;
  } wr_dec_t;
endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
  import gpio_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W = AW
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output wr_dec_t           dec
);
  always_comb begin
    dec = '0;
    if (wr_en) begin
      unique case (addr)
        OFS_DIR: dec.wr_dir  = 1'b1;
        OFS_AUX: dec.wr_aux  = 1'b1;
        OFS_SET: dec.set_stb = 1'b1;
        OFS_CLR: dec.clr_stb = 1'b1;
        default: dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_level_reg.sv
module gpio_level_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] dir,
  output logic [WIDTH-1:0] level,
  output logic             err
);
  logic             overlap;
  logic             level_en;
  logic [WIDTH-1:0] level_nxt;
  logic             err_nxt;

  assign overlap = |(mask & dir);

  always_comb begin
    level_en  = (set_stb | clr_stb) & overlap;
    level_nxt = level;
    if (set_stb)      level_nxt = level | mask;
    else if (clr_stb) level_nxt = level & ~mask;
    err_nxt   = (set_stb | clr_stb) & ~overlap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      err   <= 1'b0;
    end else begin
      if (level_en) level <= level_nxt;
      err <= err_nxt;
    end
  end

  p_reject_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_stb | clr_stb) && ((mask & dir) == '0)) |=> ($stable(level) && err));

  p_set_applies_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && ((mask & dir) != '0)) |=> ((level & $past(mask)) == $past(mask)));

  p_clr_applies_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && ((mask & dir) != '0)) |=> ((level & $past(mask)) == '0));

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> !err);
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_strobe_pkg::*;
#(
  parameter int unsigned WIDTH  = DW,
  parameter int unsigned ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  level,
  input  logic [WIDTH-1:0]  dir,
  input  logic [WIDTH-1:0]  aux,
  output logic [WIDTH-1:0]  rd_data
);
  logic [WIDTH-1:0] rd_nxt;

  always_comb begin
    unique case (addr)
      OFS_LEVEL: rd_nxt = level;
      OFS_DIR:   rd_nxt = dir;
      OFS_AUX:   rd_nxt = aux;
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_rd_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != OFS_LEVEL && addr != OFS_DIR && addr != OFS_AUX)
      |=> (rd_data == '0));
endmodule

// File: rtl/gpio_strobe_bank.sv
module gpio_strobe_bank
  import gpio_strobe_pkg::*;
#(
  parameter int unsigned WIDTH  = DW,
  parameter int unsigned ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              strobe_err
);
  wr_dec_t          dec;
  logic [WIDTH-1:0] dir_q, dir_nxt;
  logic [WIDTH-1:0] aux_q, aux_nxt;
  logic [WIDTH-1:0] level_q;

  gpio_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .dec(dec)
  );

  always_comb begin
    dir_nxt = dec.wr_dir ? wr_data : dir_q;
    aux_nxt = dec.wr_aux ? wr_data : aux_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      aux_q <= '0;
    end else begin
      dir_q <= dir_nxt;
      aux_q <= aux_nxt;
    end
  end

  gpio_level_reg #(.WIDTH(WIDTH)) u_lvl (
    .clk(clk), .rst_n(rst_n),
    .set_stb(dec.set_stb), .clr_stb(dec.clr_stb),
    .mask(wr_data), .dir(dir_q),
    .level(level_q), .err(strobe_err)
  );

  gpio_read_mux #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .level(level_q), .dir(dir_q), .aux(aux_q), .rd_data(rd_data)
  );

  assign pin_out = level_q;
  assign pin_oe  = dir_q;

  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DIR) |=> (pin_oe == $past(wr_data)));

  p_edge_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFS_RISE || addr == OFS_FALL || addr == OFS_EDGE))
      |=> ($stable(pin_out) && $stable(pin_oe) && !strobe_err));
endmodule

// File: tb/gpio_strobe_bank_tb.sv
module gpio_strobe_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [31:0] rd_data;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        strobe_err;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_lvl, m_dir, m_aux, m_rd;
  logic        m_err;

  gpio_strobe_bank u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe),
    .strobe_err(strobe_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural model step, mirrors requirements R2..R7
  task automatic model_step();
    logic [31:0] rdv;
    m_err = 1'b0;
    if (rd_en) begin
      case (addr)
        6'h00: rdv = m_lvl;
        6'h04: rdv = m_dir;
        6'h20: rdv = m_aux;
        default: rdv = 32'h0;
      endcase
      m_rd = rdv;
    end
    if (wr_en) begin
      case (addr)
        6'h04: m_dir = wr_data;
        6'h20: m_aux = wr_data;
        6'h08: if ((wr_data & m_dir) != 0) m_lvl = m_lvl | wr_data; else m_err = 1'b1;
        6'h0C: if ((wr_data & m_dir) != 0) m_lvl = m_lvl & ~wr_data; else m_err = 1'b1;
        default: ;
      endcase
    end
  endtask

  // one bus cycle, compare every output after the edge (R8 each time)
  task automatic cyc(input string req, input logic w, input logic r,
                     input logic [5:0] a, input logic [31:0] d);
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    @(posedge clk);
    model_step();
    #1;
    chk({req, "/R8 pin_out"}, pin_out, m_lvl);
    chk({req, "/R8 pin_oe"}, pin_oe, m_dir);
    chk({req, " strobe_err"}, {31'b0, strobe_err}, {31'b0, m_err});
    chk({req, " rd_data"}, rd_data, m_rd);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    cyc(req, 1'b0, 1'b1, a, 32'h0);
    chk({req, " explicit"}, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; addr = 0; wr_en = 0; wr_data = 0; rd_en = 0;
    m_lvl = 0; m_dir = 0; m_aux = 0; m_rd = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 err", {31'b0, strobe_err}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd("R1 aux", 6'h20, 32'h0);
    // R6: strobe with zero direction rejected
    cyc("R6 set dir0", 1, 0, 6'h08, 32'hFFFF_FFFF);
    cyc("R6 pulse end", 0, 0, 6'h00, 0);
    rd("R6 level", 6'h00, 32'h0);
    // R3
    cyc("R3 dir", 1, 0, 6'h04, 32'h0000_00FF);
    cyc("R3 aux", 1, 0, 6'h20, 32'hCAFE_F00D);
    rd("R3 dir rd", 6'h04, 32'h0000_00FF);
    rd("R3 aux rd", 6'h20, 32'hCAFE_F00D);
    // R4: inside mask, then partial overlap sets input bits too
    cyc("R4 set in", 1, 0, 6'h08, 32'h0000_0011);
    rd("R4 level", 6'h00, 32'h0000_0011);
    cyc("R4 set partial", 1, 0, 6'h08, 32'hF000_0100 | 32'h1);
    rd("R4 partial level", 6'h00, 32'hF000_0111);
    // R6: disjoint mask
    cyc("R6 set disjoint", 1, 0, 6'h08, 32'h0F00_0000);
    cyc("R6 clr disjoint", 1, 0, 6'h0C, 32'hF000_0000);
    rd("R6 level kept", 6'h00, 32'hF000_0111);
    // R5: partial overlap clears input bits too
    cyc("R5 clr", 1, 0, 6'h0C, 32'hF000_0001);
    rd("R5 level", 6'h00, 32'h0000_0110);
    // R7: edge slots and unmapped
    cyc("R7 rise", 1, 0, 6'h10, 32'hFFFF_FFFF);
    cyc("R7 fall", 1, 0, 6'h14, 32'hFFFF_FFFF);
    cyc("R7 edge", 1, 0, 6'h18, 32'hFFFF_FFFF);
    cyc("R7 unmapped", 1, 0, 6'h3C, 32'hFFFF_FFFF);
    rd("R7 level", 6'h00, 32'h0000_0110);
    rd("R7 dir", 6'h04, 32'h0000_00FF);
    rd("R7 aux", 6'h20, 32'hCAFE_F00D);
    // R2: unmapped reads and hold
    rd("R2 rd 0x10", 6'h10, 32'h0);
    rd("R2 rd 0x08", 6'h08, 32'h0);
    rd("R2 rd 0x04", 6'h04, 32'h0000_00FF);
    cyc("R2 hold", 0, 0, 6'h00, 0);
    chk("R2 hold explicit", rd_data, 32'h0000_00FF);
    for (int i = 0; i < 32; i++) begin
      cyc("R3 dir walk", 1, 0, 6'h04, 32'h1 << i);
      cyc("R4 set walk", 1, 0, 6'h08, 32'h1 << i);
      cyc("R6 set walk", 1, 0, 6'h08, ~(32'h1 << i));
    end
    rd("R4 walk level", 6'h00, 32'hFFFF_FFFF);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule